// File: doc/BRIEF.md
# Asynchronous Host Bus Cycle Sequencer

This block lets a fast core run single bus cycles on a slower host bus that uses an address strobe, separate upper and lower byte strobes, a read/write line, three function code lines and an active-low transfer acknowledge (DTACK). The core presents one request at a time on a valid/ready port. The request carries a byte address, byte enables, write data and a 3-bit cycle type. The sequencer drives the bus and waits for the synchronized acknowledge. It then returns read data, or an interrupt vector, with a one-clock response pulse.

An interrupt acknowledge cycle signals the level being serviced on the bus. The host may end it with the valid-peripheral line (VPA), which selects an autovector, or with DTACK, in which case a vector byte is read from the bus. One fixed pair of byte addresses belongs to a slow register pair, and cycles to either address keep their strobes asserted for a fixed number of extra clocks. The sequencer only goes back to idle once both acknowledge lines have been seen inactive again. A fast follow-on request therefore cannot mistake a lingering acknowledge for its own.

Top module: `hbus_cycle_seq`

## Requirements
- R1: While reset is applied and right after it, req_ready is 1, rsp_valid is 0, bus_as_n, bus_uds_n, bus_lds_n and bus_rw are 1, bus_doe is 0 and bus_fc is 000.
- R2: A request is taken on a clock where req_valid and req_ready are both 1. req_ready stays 0 until the cycle completes. Completion is a single-clock rsp_valid pulse, and req_ready returns to 1 in that same clock.
- R3: bus_addr, bus_rw and bus_fc settle one clock before bus_as_n and the byte strobes fall, and stay unchanged while the strobes are low. bus_as_n and both byte strobes rise in the same clock.
- R4: The cycle type selects the function code. Type 000 (data read), 001 (data write) and any unlisted code drive FC 101. Type 010 (program read) drives FC 110. Type 111 (interrupt acknowledge) drives FC 111. Every type except 001 is a read (bus_rw = 1).
- R5: bus_uds_n is asserted when req_be[1] = 1 and bus_lds_n when req_be[0] = 1. An interrupt acknowledge asserts only bus_lds_n.
- R6: In a write, bus_rw is 0 and bus_doe is 1 with bus_dout equal to the request's write data from the clock before the strobes fall until they rise. bus_doe is 0 once they have risen.
- R7: For a read, rsp_data carries the full 16-bit bus_din value that was present when the synchronized DTACK was found low.
- R8: DTACK and VPA each pass through a two-flop synchronizer. The strobes fall on a clock edge and stay low for exactly k+2 clocks when the host first drives DTACK low during the k-th clock of strobe assertion. There is no timeout.
- R9: req_ready never returns to 1 while bus_dtack_n or bus_vpa_n is still 0 from the finished cycle, however long the host holds them.
- R10: An interrupt acknowledge drives bus_addr bits 23..4 to all ones and bits 3..1 to the level taken from req_addr[3:1].
- R11: In an interrupt acknowledge, a synchronized VPA seen low no later than DTACK ends the cycle as an autovector, and rsp_data is 24 plus the level, with zeros above.
- R12: In an interrupt acknowledge where DTACK is seen low while VPA is inactive, rsp_data is bus_din[7:0] zero-extended, and bus_din[15:8] is discarded.
- R13: Reads or writes to byte address 0x18020 or 0x18021 keep the strobes low SLOW_DLY clocks (default 4) longer than the same access elsewhere. Address 0x18022 gets no extra clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_type | input | 3 | Cycle type: 000 data read, 001 data write, 010 program read, 111 interrupt acknowledge |
| req_addr | input | ADDR_W | Byte address; bits 3..1 hold the level for an interrupt acknowledge |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | DATA_W | Read data or vector number |
| bus_addr | output | ADDR_W-1 | Word address lines, bits ADDR_W-1..1 |
| bus_fc | output | 3 | Function code lines |
| bus_rw | output | 1 | 1 for read, 0 for write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper byte strobe, active low |
| bus_lds_n | output | 1 | Lower byte strobe, active low |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_vpa_n | input | 1 | Valid peripheral / autovector select, active low, asynchronous |

## Verification
The assertions assume a host that behaves like a real asynchronous target. It raises DTACK and VPA only while a cycle is open, holds bus_din stable from DTACK until the strobes rise, and releases every acknowledge some time after the strobes go away. The assertion that ties a rising req_ready to an inactive DTACK three samples back relies on that host never pulsing an acknowledge while the block is idle. The host model in the bench keeps to these rules. It makes VPA the NAND of FC1 and FC0, gated by a test switch so that vector-from-bus acknowledges can also be run. It asserts DTACK a programmed number of clocks into the strobe phase and releases it a programmed number of clocks after the strobes rise, so the acknowledges never move on their own.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_STRB  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_DRAIN = 3'd4
   } seq_state_e;

   localparam logic [2:0] TY_DREAD  = 3'b000;
   localparam logic [2:0] TY_DWRITE = 3'b001;
   localparam logic [2:0] TY_PREAD  = 3'b010;
   localparam logic [2:0] TY_IACK   = 3'b111;

   localparam logic [2:0] FC_NONE  = 3'b000;
   localparam logic [2:0] FC_SDATA = 3'b101;
   localparam logic [2:0] FC_SPROG = 3'b110;
   localparam logic [2:0] FC_IACK  = 3'b111;

   localparam logic [7:0] AUTOVEC_BASE = 8'd24;

   function automatic logic [2:0] fc_of(input logic [2:0] ty);
      logic [2:0] fc;
      case (ty)
         TY_PREAD: fc = FC_SPROG;
         TY_IACK:  fc = FC_IACK;
         default:  fc = FC_SDATA;
      endcase
      return fc;
   endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbus_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hbus_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hbus_slow_match.sv
module hbus_slow_match #(
   parameter int          ADDR_W    = 24,
   parameter logic [31:0] SLOW_BASE = 32'h0001_8020
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] LO_A = SLOW_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] HI_A = LO_A + ADDR_W'(1);

   generate
      if (SLOW_BASE[0] != 1'b0) begin : g_bad_base
         $error("hbus_slow_match: SLOW_BASE must be even");
      end
   endgenerate

   // Both bytes of the slow register word are matched.
   assign hit = (addr == LO_A) || (addr == HI_A);

endmodule

// File: rtl/hbus_hold_cnt.sv
module hbus_hold_cnt #(
   parameter int DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   generate
      if (DLY < 0) begin : g_bad_dly
         $error("hbus_hold_cnt: DLY must not be negative");
      end else if (DLY == 0) begin : g_none
         assign last = 1'b1;
      end else begin : g_cnt
         localparam int             CW     = $clog2(DLY + 1);
         localparam logic [CW-1:0] LAST_V = CW'(DLY - 1);

         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (!run || cnt_q == LAST_V)  cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;
         end

         assign last = run && (cnt_q == LAST_V);

         // R13: the hold window never counts past its programmed length
         p_hold_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST_V);
         // R13: every hold window starts from a cleared count
         p_hold_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run) |-> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/hbus_cycle_seq.sv
module hbus_cycle_seq
   import hbus_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          DATA_W      = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int          SLOW_DLY    = 4,
   parameter logic [31:0] SLOW_BASE   = 32'h0001_8020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:1] bus_addr,
   output logic [2:0]        bus_fc,
   output logic              bus_rw,
   output logic              bus_as_n,
   output logic              bus_uds_n,
   output logic              bus_lds_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_dtack_n,
   input  logic              bus_vpa_n
);

   localparam int  HI_W     = ADDR_W - 4;
   localparam int  VEC_PAD  = DATA_W - 8;
   localparam bit  HAS_SLOW = (SLOW_DLY > 0);

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("hbus_cycle_seq: DATA_W must be 16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("hbus_cycle_seq: ADDR_W must lie in 8..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbus_cycle_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic [2:0]        ty_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        be_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rsp_q, rsp_d;
   logic              rspv_q, rspv_d;

   // Acknowledge synchronizers
   logic dtack_s, vpa_s;
   hbus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_dtack_n, bus_vpa_n}),
      .q     ({dtack_s, vpa_s})
   );

   // Slow register pair decode
   logic slow_hit;
   hbus_slow_match #(.ADDR_W(ADDR_W), .SLOW_BASE(SLOW_BASE)) u_slow (
      .addr (addr_q),
      .hit  (slow_hit)
   );

   // Extra strobe time for the slow pair
   logic hold_run, hold_last;
   assign hold_run = (state_q == ST_HOLD);
   hbus_hold_cnt #(.DLY(SLOW_DLY)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (hold_run),
      .last  (hold_last)
   );

   logic       is_iack, is_wr, want_hold, ack_vpa, ack_dt;
   logic [2:0] lvl;
   logic [7:0] autovec;

   assign is_iack   = (ty_q == TY_IACK);
   assign is_wr     = (ty_q == TY_DWRITE);
   assign lvl       = addr_q[3:1];
   assign autovec   = AUTOVEC_BASE + {5'd0, lvl};
   assign want_hold = HAS_SLOW && slow_hit && !is_iack;
   assign ack_vpa   = is_iack && !vpa_s;
   assign ack_dt    = !dtack_s;

   always_comb begin
      state_d = state_q;
      rsp_d   = rsp_q;
      rspv_d  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) state_d = ST_ADDR;
         end
         ST_ADDR: begin
            state_d = ST_STRB;
         end
         ST_STRB: begin
            if (ack_vpa) begin
               // autovector wins when seen no later than DTACK
               rsp_d   = {{VEC_PAD{1'b0}}, autovec};
               state_d = ST_DRAIN;
            end else if (ack_dt) begin
               if (is_iack)     rsp_d = {{VEC_PAD{1'b0}}, bus_din[7:0]};
               else if (!is_wr) rsp_d = bus_din;
               state_d = want_hold ? ST_HOLD : ST_DRAIN;
            end
         end
         ST_HOLD: begin
            if (hold_last) state_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            // both acknowledges must be seen released before idling
            if (dtack_s && vpa_s) begin
               state_d = ST_IDLE;
               rspv_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ty_q    <= TY_DREAD;
         addr_q  <= '0;
         be_q    <= '0;
         wd_q    <= '0;
         rsp_q   <= '0;
         rspv_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         rsp_q   <= rsp_d;
         rspv_q  <= rspv_d;
         if (state_q == ST_IDLE && req_valid) begin
            ty_q   <= req_type;
            addr_q <= req_addr;
            be_q   <= req_be;
            wd_q   <= req_wdata;
         end
      end
   end

   logic bus_active, strobe_on;
   assign bus_active = (state_q == ST_ADDR) || (state_q == ST_STRB) || (state_q == ST_HOLD);
   assign strobe_on  = (state_q == ST_STRB) || (state_q == ST_HOLD);

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = rspv_q;
   assign rsp_data  = rsp_q;

   assign bus_addr  = is_iack ? {{HI_W{1'b1}}, lvl} : addr_q[ADDR_W-1:1];
   assign bus_fc    = bus_active ? fc_of(ty_q) : FC_NONE;
   assign bus_rw    = !(bus_active && is_wr);
   assign bus_as_n  = !strobe_on;
   assign bus_uds_n = !(strobe_on && !is_iack && be_q[1]);
   assign bus_lds_n = !(strobe_on && (is_iack || be_q[0]));
   assign bus_dout  = wd_q;
   assign bus_doe   = bus_active && is_wr;

   // R9: idle is re-entered only after both acknowledges were released
   p_idle_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> ($past(bus_dtack_n, 3) && $past(bus_vpa_n, 3)));
   // R3: address, direction and function code settle before the strobe falls
   p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_as_n) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_rw)));
   // R3: all strobes are released in the same clock
   p_strobe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_as_n) |-> (bus_uds_n && bus_lds_n));
   // R6: a strobed write always has its data driven
   p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && !bus_rw) |-> bus_doe);
   // R2: the completion indication lasts a single clock
   p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R2: no completion while a request is still being taken
   p_rsp_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

endmodule

// File: tb/hbus_cycle_seq_tb_top.sv
module hbus_cycle_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SLOW_X     = 4;

   typedef struct packed {
      logic [22:0] addr;
      logic [2:0]  fc;
      logic        rw;
      logic        uds_n;
      logic        lds_n;
      logic        wr;
      logic [15:0] wd;
      logic        chk_len;
      logic [7:0]  len;
   } bus_exp_t;

   typedef struct packed {
      logic        chk;
      logic [15:0] val;
   } rsp_exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_type = 3'b000;
   logic [23:0] req_addr = '0;
   logic [1:0]  req_be = 2'b11;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic [23:1] bus_addr;
   logic [2:0]  bus_fc;
   logic        bus_rw, bus_as_n, bus_uds_n, bus_lds_n, bus_doe;
   logic [15:0] bus_dout;
   logic [15:0] bus_din = '0;
   logic        bus_dtack_n = 1'b1;
   logic        bus_vpa_n;

   int  n_chk = 0;
   int  n_err = 0;
   int  ack_lat = 3;
   int  rel_lat = 0;
   bit  vpa_en = 1'b1;

   bus_exp_t bus_q[$];
   rsp_exp_t rsp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // Host side: VPA is the NAND of FC1 and FC0 when enabled
   assign bus_vpa_n = vpa_en ? !(bus_fc[1] & bus_fc[0]) : 1'b1;

   hbus_cycle_seq #(.SLOW_DLY(SLOW_X)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw),
      .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
      .bus_dtack_n(bus_dtack_n), .bus_vpa_n(bus_vpa_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   // Monitor and host model, all at the falling edge
   logic        as_prev = 1'b1, rsp_prev = 1'b0;
   logic [23:1] addr_prev = '0;
   logic [2:0]  fc_prev = '0;
   logic        rw_prev = 1'b1;
   int          as_cnt = 0, rel_cnt = 0;
   bit          rel_pend = 1'b0;
   bus_exp_t    cur;

   always @(negedge clk) begin
      if (rst_n) begin
         // R9: never idle while an acknowledge is still held
         if (req_ready) begin
            chk(bus_dtack_n && bus_vpa_n, "R9 ready with ack held",
                {30'd0, bus_dtack_n, bus_vpa_n}, 32'h3);
         end
         if (rsp_valid) begin
            chk(!rsp_prev, "R2 single pulse", {31'd0, rsp_prev}, 32'h0);
            chk(req_ready, "R2 ready with response", {31'd0, req_ready}, 32'h1);
            if (rsp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected response", 32'd1, 32'd0);
            end else begin
               rsp_exp_t r;
               r = rsp_q.pop_front();
               if (r.chk) chk(rsp_data == r.val, "R7 R11 R12 response data", {16'd0, rsp_data}, {16'd0, r.val});
            end
         end
         if (!bus_as_n) begin
            if (as_prev) begin
               as_cnt = 1;
               chk(bus_addr == addr_prev && bus_fc == fc_prev && bus_rw == rw_prev,
                   "R3 setup before strobe", {5'd0, bus_addr, bus_fc, bus_rw}, {5'd0, addr_prev, fc_prev, rw_prev});
               if (bus_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected bus cycle", 32'd1, 32'd0);
                  cur = '0;
               end else begin
                  cur = bus_q.pop_front();
                  chk(bus_addr == cur.addr, "R10 bus address", {9'd0, bus_addr}, {9'd0, cur.addr});
                  chk(bus_fc == cur.fc, "R4 function code", {29'd0, bus_fc}, {29'd0, cur.fc});
                  chk(bus_rw == cur.rw, "R4 direction", {31'd0, bus_rw}, {31'd0, cur.rw});
                  chk({bus_uds_n, bus_lds_n} == {cur.uds_n, cur.lds_n}, "R5 byte strobes",
                      {30'd0, bus_uds_n, bus_lds_n}, {30'd0, cur.uds_n, cur.lds_n});
               end
            end else begin
               as_cnt++;
            end
            if (cur.wr) begin
               chk(bus_doe && bus_dout == cur.wd, "R6 write data driven",
                   {15'd0, bus_doe, bus_dout}, {15'd0, 1'b1, cur.wd});
            end
            if (as_cnt == ack_lat && bus_vpa_n) begin
               bus_dtack_n = 1'b0;
               if (bus_fc == 3'b111) bus_din = {8'hEE, 5'b01000, bus_addr[3:1]};
               else                  bus_din = bus_addr[16:1] ^ 16'h5A3C;
            end
         end else if (!as_prev) begin
            chk({bus_uds_n, bus_lds_n} == 2'b11, "R3 strobes rise together",
                {30'd0, bus_uds_n, bus_lds_n}, 32'h3);
            chk(!bus_doe, "R6 data released", {31'd0, bus_doe}, 32'h0);
            if (cur.chk_len) chk(as_cnt == int'(cur.len), "R8 R13 strobe length", as_cnt, {24'd0, cur.len});
            rel_cnt = 0;
            if (rel_lat == 0) bus_dtack_n = 1'b1;
            else              rel_pend = 1'b1;
         end else if (rel_pend) begin
            rel_cnt++;
            if (rel_cnt >= rel_lat) begin
               bus_dtack_n = 1'b1;
               rel_pend = 1'b0;
            end
         end
         as_prev   = bus_as_n;
         rsp_prev  = rsp_valid;
         addr_prev = bus_addr;
         fc_prev   = bus_fc;
         rw_prev   = bus_rw;
      end
   end

   // Driver: builds expected items then runs the handshake
   task automatic issue(input logic [2:0] ty, input logic [23:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input bit rchk, input logic [15:0] rexp,
                        input bit lchk, input int len);
      bus_exp_t e;
      rsp_exp_t r;
      e.addr    = (ty == 3'b111) ? {20'hFFFFF, a[3:1]} : a[23:1];
      e.fc      = (ty == 3'b111) ? 3'b111 : (ty == 3'b010) ? 3'b110 : 3'b101;
      e.rw      = (ty != 3'b001);
      e.uds_n   = (ty == 3'b111) ? 1'b1 : !be[1];
      e.lds_n   = (ty == 3'b111) ? 1'b0 : !be[0];
      e.wr      = (ty == 3'b001);
      e.wd      = wd;
      e.chk_len = lchk;
      e.len     = 8'(len);
      r.chk     = rchk;
      r.val     = rexp;
      bus_q.push_back(e);
      rsp_q.push_back(r);
      while (!req_ready) @(negedge clk);
      req_type  = ty;
      req_addr  = a;
      req_be    = be;
      req_wdata = wd;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R2 busy after accept", {31'd0, req_ready}, 32'h0);
      while (!req_ready) @(negedge clk);
   endtask

   function automatic logic [15:0] rd_of(input logic [23:0] a);
      return a[16:1] ^ 16'h5A3C;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk(req_ready && !rsp_valid, "R1 handshake in reset", {30'd0, req_ready, rsp_valid}, 32'h2);
      chk({bus_as_n, bus_uds_n, bus_lds_n, bus_rw} == 4'hF, "R1 strobes idle in reset",
          {28'd0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw}, 32'hF);
      chk(!bus_doe && bus_fc == 3'b000, "R1 bus idle in reset", {28'd0, bus_doe, bus_fc}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && bus_as_n, "R1 idle after reset",
          {29'd0, req_ready, rsp_valid, bus_as_n}, 32'h5);

      ack_lat = 3; rel_lat = 0; vpa_en = 1'b1;
      // R7 R4 R5 R8: word data read
      issue(3'b000, 24'h001234, 2'b11, 16'h0, 1'b1, rd_of(24'h001234), 1'b1, 5);
      // R6 R5: upper-byte write
      issue(3'b001, 24'h0ABCDE, 2'b10, 16'hBEEF, 1'b0, 16'h0, 1'b1, 5);
      // R4: program read, lower byte
      issue(3'b010, 24'h000401, 2'b01, 16'h0, 1'b1, rd_of(24'h000401), 1'b1, 5);
      // R4: unlisted code behaves as data read
      issue(3'b100, 24'h002000, 2'b11, 16'h0, 1'b1, rd_of(24'h002000), 1'b1, 5);
      // R8 R9: short acknowledge, long release
      ack_lat = 1; rel_lat = 6;
      issue(3'b000, 24'h003456, 2'b11, 16'h0, 1'b1, rd_of(24'h003456), 1'b1, 3);
      issue(3'b001, 24'h003458, 2'b11, 16'h1357, 1'b0, 16'h0, 1'b1, 3);
      // R13: slow pair both bytes, and the neighbour
      ack_lat = 3; rel_lat = 2;
      issue(3'b000, 24'h018020, 2'b10, 16'h0, 1'b1, rd_of(24'h018020), 1'b1, 5 + SLOW_X);
      issue(3'b001, 24'h018021, 2'b01, 16'h00A5, 1'b0, 16'h0, 1'b1, 5 + SLOW_X);
      issue(3'b000, 24'h018022, 2'b11, 16'h0, 1'b1, rd_of(24'h018022), 1'b1, 5);
      // R10 R11: autovector acknowledges
      issue(3'b111, 24'h00000A, 2'b00, 16'h0, 1'b1, 16'd29, 1'b0, 0);
      issue(3'b111, 24'h00000E, 2'b11, 16'h0, 1'b1, 16'd31, 1'b0, 0);
      // R12: vector byte from the bus
      vpa_en = 1'b0;
      issue(3'b111, 24'h000004, 2'b00, 16'h0, 1'b1, 16'h0042, 1'b1, 5);
      vpa_en = 1'b1;
      // R9: back-to-back with held acknowledge
      rel_lat = 5; ack_lat = 2;
      issue(3'b000, 24'h004000, 2'b11, 16'h0, 1'b1, rd_of(24'h004000), 1'b1, 4);
      issue(3'b000, 24'h004002, 2'b11, 16'h0, 1'b1, rd_of(24'h004002), 1'b1, 4);

      repeat (10) @(negedge clk);
      chk(bus_q.size() == 0 && rsp_q.size() == 0, "R2 all items seen",
          bus_q.size() + rsp_q.size(), 32'd0);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule